// File: doc/BRIEF.md
# Edge-Strobed Watchdog Timer

This block watches a strobe line driven by a processor and raises an alarm when the line stops moving. A rising or a falling transition on the strobe restarts a timeout. The timeout is counted in pulses of a slow timebase enable, for example one per millisecond. Its length is picked from three settings by a 2-bit select code. If no transition arrives before the timeout runs out, the active-low status output drops for a fixed number of clock cycles. The timeout then restarts by itself, so a stalled processor sees repeated pulses.

The watchdog runs only while the system reports that at least one reset output is released. While every reset is asserted, the counter is held cleared and the status output stays high. The block has no way to switch the watchdog off. A system that does not want the alarm leaves the status output unconnected. The strobe passes through a two-stage synchronizer on the fast system clock. Any strobe level held for one clock period is therefore seen.

Top module: `strobe_watchdog`

## Requirements
- R1: After reset the status output `status_n_o` is high and the timeout counter is cleared.
- R2: A rising or a falling transition on `strobe_i` restarts the timeout. It does so two clock edges after the first edge that samples the new level. A strobe level held for one clock period is enough.
- R3: The select code `dly_sel_i` picks the timeout length in timebase pulses: 2'b00 gives T_SHORT, 2'b01 gives T_MID, and 2'b10 or 2'b11 give T_LONG.
- R4: The counter advances only on clock edges where `tick_i` is high. The status output falls at the clock edge that carries the T-th tick after a restart. Without ticks, no timeout occurs.
- R5: A timeout holds `status_n_o` low for exactly PULSE_CYCLES clock cycles.
- R6: When a pulse ends, the timeout restarts from zero at once. With no strobe transition, the next pulse begins T ticks later.
- R7: While `run_i` is low, no timing takes place. The status output is high from the next clock edge, and the counter is cleared. After `run_i` rises, a full timeout is counted.
- R8: The select code is captured at each restart: when timing starts, on a strobe transition, and at the end of a pulse. A change during a count applies from the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | Activity strobe from the processor, asynchronous |
| dly_sel_i | input | 2 | Timeout length select code |
| run_i | input | 1 | High when at least one reset output is released |
| tick_i | input | 1 | Timebase enable, one clock cycle wide |
| status_n_o | output | 1 | Active-low timeout pulse |

## Verification
A counter that drifts, or a limit captured from the wrong select code, shows up as a status edge one or more clock cycles away from its computed position. The bench counts clock edges from a known stimulus, such as a rise of `run_i`, a strobe toggle or the end of a pulse. It compares that count exactly against the value worked out from the requirements. Such an error is therefore caught at the first pulse after the fault. A state machine stuck in its pulse or idle state shows at once: the low level lasts longer than PULSE_CYCLES, or the status output fails to return high one edge after `run_i` drops.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_COUNT = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_e;

  localparam logic [1:0] SEL_SHORT = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_LONG  = 2'b10;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/wdt_edge_det.sv
module wdt_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic toggle_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sig_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  // Either polarity counts as activity.
  assign toggle_o = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int T_SHORT      = 16,
  parameter int T_MID        = 160,
  parameter int T_LONG       = 1600,
  parameter int PULSE_CYCLES = 10000,
  localparam int CNT_W       = $clog2(T_LONG + 1),
  localparam int PW          = $clog2(PULSE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [1:0]       sel_i,
  output logic             expired_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [CNT_W-1:0] sel_lim;

  always_comb begin
    case (sel_i)
      SEL_SHORT: sel_lim = CNT_W'(T_SHORT);
      SEL_MID:   sel_lim = CNT_W'(T_MID);
      default:   sel_lim = CNT_W'(T_LONG);
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    pcnt_d  = pcnt_q;
    if (!run_i) begin
      state_d = WD_IDLE;
      cnt_d   = '0;
      pcnt_d  = '0;
    end else begin
      case (state_q)
        WD_IDLE: begin
          state_d = WD_COUNT;
          cnt_d   = '0;
          lim_d   = sel_lim;
        end
        WD_COUNT: begin
          if (kick_i) begin
            cnt_d = '0;
            lim_d = sel_lim;
          end else if (tick_i) begin
            if (cnt_q == lim_q - CNT_W'(1)) begin
              state_d = WD_PULSE;
              cnt_d   = '0;
              pcnt_d  = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        WD_PULSE: begin
          if (pcnt_q == PW'(PULSE_CYCLES - 1)) begin
            state_d = WD_COUNT;
            cnt_d   = '0;
            lim_d   = sel_lim;
          end else begin
            pcnt_d = pcnt_q + PW'(1);
          end
        end
        default: state_d = WD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign expired_o = (state_q == WD_PULSE);
  assign cnt_o     = cnt_q;
  assign lim_o     = lim_q;

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int T_SHORT      = 16,
  parameter int T_MID        = 160,
  parameter int T_LONG       = 1600,
  parameter int PULSE_CYCLES = 10000,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(T_LONG + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] dly_sel_i,
  input  logic       run_i,
  input  logic       tick_i,
  output logic       status_n_o
);

  logic             rst_sync_n;
  logic             kick_w;
  logic             expired_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] lim_w;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  wdt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sig_i    (strobe_i),
    .toggle_o (kick_w)
  );

  wdt_timer #(
    .T_SHORT      (T_SHORT),
    .T_MID        (T_MID),
    .T_LONG       (T_LONG),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .run_i     (run_i),
    .tick_i    (tick_i),
    .kick_i    (kick_w),
    .sel_i     (dly_sel_i),
    .expired_o (expired_w),
    .cnt_o     (cnt_w),
    .lim_o     (lim_w)
  );

  assign status_n_o = ~expired_w;

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             run_i,
  input logic             tick_i,
  input logic             status_n_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] lim_w
);

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_i |=> status_n_o);

  // R5 (PULSE_CYCLES of two or more)
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(status_n_o) && run_i) |=> !status_n_o);

  // R4
  tick_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(status_n_o) |-> $past(tick_i));

  // R4
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lim_w != '0) |-> (cnt_w < lim_w));

endmodule

bind strobe_watchdog strobe_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .run_i      (run_i),
  .tick_i     (tick_i),
  .status_n_o (status_n_o),
  .cnt_w      (cnt_w),
  .lim_w      (lim_w)
);

// File: tb/strobe_watchdog_test.sv
module strobe_watchdog_test;

  localparam int TS = 8;
  localparam int TM = 14;
  localparam int TL = 24;
  localparam int PC = 6;

  // {select code, expected edges from run rise to pulse = T + 1}
  localparam logic [9:0] VEC [0:3] = '{
    {2'b00, 8'd9}, {2'b01, 8'd15}, {2'b10, 8'd25}, {2'b11, 8'd25}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe;
  logic [1:0] sel;
  logic       run;
  logic       tick;
  logic       status_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  strobe_watchdog #(
    .T_SHORT(TS), .T_MID(TM), .T_LONG(TL), .PULSE_CYCLES(PC)
  ) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .strobe_i   (strobe),
    .dly_sel_i  (sel),
    .run_i      (run),
    .tick_i     (tick),
    .status_n_o (status_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic edges_to_low(output int n);
    n = 0;
    do begin step(); n++; end while (status_n && n < 2000);
  endtask

  task automatic edges_to_high(output int n);
    n = 0;
    do begin step(); n++; end while (!status_n && n < 2000);
  endtask

  task automatic restart_run(input logic [1:0] s);
    run = 1'b0;
    sel = s;
    step();
    step();
    run = 1'b1;
  endtask

  initial begin
    int n;
    int lows;
    rst_n  = 1'b0;
    strobe = 1'b0;
    sel    = 2'b00;
    run    = 1'b0;
    tick   = 1'b1;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (4) step();
    check(status_n == 1'b1, "R1 status after reset", status_n, 1);

    // R3: table of select codes
    for (int i = 0; i < 4; i++) begin
      restart_run(VEC[i][9:8]);
      edges_to_low(n);
      check(n == int'(VEC[i][7:0]), "R3 timeout per select code", n, VEC[i][7:0]);
    end

    // R5 pulse width, R6 automatic restart
    restart_run(2'b00);
    edges_to_low(n);
    check(n == TS + 1, "R4 first timeout", n, TS + 1);
    edges_to_high(n);
    check(n == PC, "R5 pulse width", n, PC);
    edges_to_low(n);
    check(n == TS, "R6 automatic restart interval", n, TS);

    // R2 rising strobe edge
    restart_run(2'b00);
    repeat (3) step();
    strobe = 1'b1;
    edges_to_low(n);
    check(n == TS + 3, "R2 rising strobe restarts", n, TS + 3);

    // R2 falling strobe edge
    restart_run(2'b00);
    repeat (3) step();
    strobe = 1'b0;
    edges_to_low(n);
    check(n == TS + 3, "R2 falling strobe restarts", n, TS + 3);

    // R8 select captured at restart
    restart_run(2'b00);
    step();
    sel = 2'b10;
    edges_to_low(n);
    check(n + 1 == TS + 1, "R8 mid-count select ignored", n + 1, TS + 1);
    edges_to_high(n);
    edges_to_low(n);
    check(n == TL, "R8 new select at next restart", n, TL);

    // R7 run drop during count
    restart_run(2'b00);
    repeat (5) step();
    run  = 1'b0;
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (!status_n) lows++;
    end
    check(lows == 0, "R7 no timing while run low", lows, 0);
    run = 1'b1;
    edges_to_low(n);
    check(n == TS + 1, "R7 full count after run rises", n, TS + 1);

    // R7 run drop during pulse
    run = 1'b0;
    step();
    check(status_n == 1'b1, "R7 pulse released on run low", status_n, 1);

    // R4 tick gating
    tick = 1'b0;
    restart_run(2'b00);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (!status_n) lows++;
    end
    check(lows == 0, "R4 no progress without ticks", lows, 0);
    tick = 1'b1;
    edges_to_low(n);
    check(n == TS, "R4 timeout counted in ticks", n, TS);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule